// File: doc/BRIEF.md
# Maskable Interrupt Status With Read-Clear

This block gathers twelve event sources of a serial-bus controller into one raw status word. Ten of the sources are pulses that are latched until software clears them. Two are levels (receive data reached its threshold, transmit data fell to its threshold) that follow their conditions directly. A mask register selects which raw bits reach the interrupt status word. The single interrupt output is active whenever any masked bit is set.

Software clears latched events by reading. Each latched event has its own clearing address, and one further address clears all of them in one access. The value returned by a clearing read tells software whether anything was pending before the read. The port is a plain register interface with one shared address, separate read and write strobes, and combinational read data.

Top module: `intr_stat_rc`

## Requirements
- R1: After reset every latched event bit is 0, the mask (offset 0x30) reads 0 and `irq` is 0.
- R2: A 1 on `ev_set[k]` for a latched bit k (all bits except 2 and 4) sets raw bit k from the next cycle on, and the bit stays set until cleared. The raw word at offset 0x34 shows it whatever the mask holds. Bit order: 0 RX underflow, 1 RX overflow, 2 RX full, 3 TX overflow, 4 TX empty, 5 read request, 6 TX abort, 7 RX done, 8 activity, 9 stop seen, 10 start seen, 11 general call.
- R3: Raw bit 2 equals `rx_full_lvl` and raw bit 4 equals `tx_empty_lvl` in the same cycle. `ev_set` bits 2 and 4 have no effect.
- R4: A write to offset 0x30 loads the mask from `wdata[11:0]`. A read of 0x30 returns the mask. A read of 0x2C returns the raw word ANDed with the mask. All unused upper data bits read 0.
- R5: `irq` is 1 exactly when the raw word ANDed with the mask is non-zero.
- R6: A read of a per-event clear address clears only that latched bit from the next cycle on. Bit 0 of the read data is 1 if the bit was set before the read and 0 otherwise. Addresses 0x44, 0x48, 0x4C, 0x50, 0x54, 0x58, 0x5C, 0x60, 0x64 and 0x68 map to bits 0, 1, 3, 5, 6, 7, 8, 9, 10 and 11 respectively.
- R7: A read of 0x40 clears all latched bits from the next cycle on. Bit 0 of the read data is 1 if any latched bit was set before the read.
- R8: Clearing reads leave raw bits 2 and 4 unchanged.
- R9: When `ev_set[k]` and a read that clears bit k occur in the same cycle, bit k is set afterwards.
- R10: Writes to any address other than 0x30 change no state. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_set | input | 12 | Event pulses, one per raw bit |
| rx_full_lvl | input | 1 | Receive-threshold level condition |
| tx_empty_lvl | input | 1 | Transmit-threshold level condition |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (required for clearing) |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| irq | output | 1 | OR of the masked status bits |

## Verification
A vector table pairs event patterns with mask patterns: a single bit with a matching mask, a bit outside the mask, all pulses with no mask, and pulses only on the level positions. Mixed sparse patterns separate the raw word from the masked word and from `irq`. Directed sequences then walk every clear address to show each one touches only its own bit. They also check clear-all against held levels, a set and a clear that collide in one cycle, and writes to the read-only words.

// File: rtl/intr_stat_rc.sv
module intr_stat_rc #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       ev_set,
  input  logic              rx_full_lvl,
  input  logic              tx_empty_lvl,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int NEV = 12;
  localparam int NCLR = 10;
  localparam logic [NEV-1:0] LATCHED = 12'hFEB;
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFS_RAW  = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] OFS_ALL  = ADDR_W'(8'h40);
  localparam int OFS_ONE0 = 8'h44;

  function automatic int clr_bit(input int k);
    case (k)
      0: return 0;
      1: return 1;
      2: return 3;
      3: return 5;
      4: return 6;
      5: return 7;
      6: return 8;
      7: return 9;
      8: return 10;
      default: return 11;
    endcase
  endfunction

  logic [NEV-1:0] lat_q, mask_q, raw, stat, clr;

  assign raw  = (lat_q & LATCHED) | {7'b0, tx_empty_lvl, 1'b0, rx_full_lvl, 2'b0};
  assign stat = raw & mask_q;
  assign irq  = |stat;

  always_comb begin
    clr = '0;
    if (rd_en && addr == OFS_ALL) clr = LATCHED;
    for (int k = 0; k < NCLR; k++)
      if (rd_en && addr == ADDR_W'(OFS_ONE0 + 4 * k)) clr[clr_bit(k)] = 1'b1;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_STAT: rdata = DATA_W'(stat);
      OFS_MASK: rdata = DATA_W'(mask_q);
      OFS_RAW:  rdata = DATA_W'(raw);
      OFS_ALL:  rdata = DATA_W'(|(lat_q & LATCHED));
      default:
        for (int k = 0; k < NCLR; k++)
          if (addr == ADDR_W'(OFS_ONE0 + 4 * k)) rdata = DATA_W'(lat_q[clr_bit(k)]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q  <= '0;
      mask_q <= '0;
    end else begin
      lat_q <= ((lat_q & ~clr) | ev_set) & LATCHED;
      if (wr_en && addr == OFS_MASK) mask_q <= wdata[NEV-1:0];
    end
  end
endmodule

// File: rtl/intr_stat_rc_chk.sv
module intr_stat_rc_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [11:0]       ev_set,
  input logic              rx_full_lvl,
  input logic              tx_empty_lvl,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [11:0]       raw,
  input logic [11:0]       mask,
  input logic              irq
);
  // R2
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set[0] |=> raw[0]);
  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set[1] && rd_en && addr == ADDR_W'(8'h48)) |=> raw[1]);
  // R6
  one_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(8'h44) && !ev_set[0]) |=> !raw[0]);
  // R7
  all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(8'h40) && ev_set == 12'h0) |=> ((raw & 12'hFEB) == 12'h0));
  // R5
  masked_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 12'h0) |-> !irq);
  // R5
  masked_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_set[6] && mask[6] && $stable(mask)) |=> irq);
  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full_lvl && tx_empty_lvl) |-> (raw[2] && raw[4]));
endmodule

bind intr_stat_rc intr_stat_rc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .rx_full_lvl(rx_full_lvl),
  .tx_empty_lvl(tx_empty_lvl), .rd_en(rd_en), .addr(addr),
  .raw(raw), .mask(mask_q), .irq(irq)
);

// File: tb/intr_stat_rc_bench.sv
module intr_stat_rc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int NVEC = 6;
  // {ev, mask, exp_raw, exp_stat, exp_irq}
  localparam logic [48:0] VEC [NVEC] = '{
    {12'h001, 12'h001, 12'h001, 12'h001, 1'b1},
    {12'h800, 12'h001, 12'h800, 12'h000, 1'b0},
    {12'hFFF, 12'h000, 12'hFEB, 12'h000, 1'b0},
    {12'h014, 12'hFFF, 12'h000, 12'h000, 1'b0},
    {12'h240, 12'h040, 12'h240, 12'h040, 1'b1},
    {12'hA5A, 12'h0F0, 12'hA4A, 12'h040, 1'b1}
  };
  localparam int CBIT [10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};

  logic clk = 0, rst_n = 0;
  logic [11:0] ev_set = '0;
  logic rx_full_lvl = 0, tx_empty_lvl = 0, wr_en = 0, rd_en = 0, irq;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, rv;
  int checks = 0, errors = 0;
  bit done = 0;

  intr_stat_rc #(.ADDR_W(AW), .DATA_W(DW)) u_intr_stat_rc (
    .clk(clk), .rst_n(rst_n), .ev_set(ev_set), .rx_full_lvl(rx_full_lvl),
    .tx_empty_lvl(tx_empty_lvl), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0; addr = '0;
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata; addr = '0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = '0; wdata = '0;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); ev_set = e;
    @(negedge clk); ev_set = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(8'h34, rv); check("R1 raw", rv, 0);
    peek(8'h30, rv); check("R1 mask", rv, 0);
    check("R1 irq", {31'b0, irq}, 0);

    // Table walk: R2 R3 R4 R5
    for (int i = 0; i < NVEC; i++) begin
      rd(8'h40, rv);
      wr(8'h30, {20'b0, VEC[i][36:25]});
      pulse(VEC[i][48:37]);
      peek(8'h34, rv); check("R2 raw", rv, {20'b0, VEC[i][24:13]});
      peek(8'h2C, rv); check("R4 stat", rv, {20'b0, VEC[i][12:1]});
      check("R5 irq", {31'b0, irq}, {31'b0, VEC[i][0]});
    end
    rd(8'h40, rv);
    peek(8'h30, rv); check("R4 mask readback", rv, 32'h0F0);

    // R3 / R8 levels
    rx_full_lvl = 1; tx_empty_lvl = 1;
    peek(8'h34, rv); check("R3 levels", rv, 32'h014);
    rd(8'h40, rv); check("R7 nothing latched", rv, 0);
    peek(8'h34, rv); check("R8 levels after clear-all", rv, 32'h014);
    rd(8'h4C, rv);
    peek(8'h34, rv); check("R8 levels after one clear", rv, 32'h014);
    rx_full_lvl = 0;
    peek(8'h34, rv); check("R3 rx level drop", rv, 32'h010);
    tx_empty_lvl = 0;

    // R6 each clear address hits only its bit
    for (int k = 0; k < 10; k++) begin
      pulse(12'hFEB);
      rd(AW'(8'h44 + 4 * k), rv); check("R6 clear returns set", rv, 1);
      peek(8'h34, rv); check("R6 only own bit", rv, 32'hFEB & ~(32'h1 << CBIT[k]));
      rd(AW'(8'h44 + 4 * k), rv); check("R6 second read 0", rv, 0);
      rd(8'h40, rv);
    end

    // R7
    pulse(12'h900);
    rd(8'h40, rv); check("R7 clear-all returns 1", rv, 1);
    peek(8'h34, rv); check("R7 all cleared", rv, 0);
    rd(8'h40, rv); check("R7 second read 0", rv, 0);

    // R9 collision
    pulse(12'h008);
    @(negedge clk); ev_set = 12'h008; addr = 8'h4C; rd_en = 1;
    @(negedge clk); ev_set = 0; rd_en = 0; addr = 0;
    peek(8'h34, rv); check("R9 set wins", rv, 32'h008);
    rd(8'h40, rv);

    // R5 irq follows mask
    wr(8'h30, 32'h200);
    pulse(12'h200);
    check("R5 irq on", {31'b0, irq}, 1);
    wr(8'h30, 32'h0);
    check("R5 irq off after unmask", {31'b0, irq}, 0);

    // R10 writes elsewhere ignored, unmapped read
    wr(8'h34, 32'hFFF); wr(8'h2C, 32'hFFF); wr(8'h40, 32'hFFF);
    peek(8'h30, rv); check("R10 mask unchanged", rv, 0);
    peek(8'h34, rv); check("R10 raw unchanged", rv, 32'h200);
    peek(8'h3C, rv); check("R10 unmapped read", rv, 0);
    rd(8'h60, rv); check("R10 raw bit 9 clear via 0x60", rv, 1);

    finish_run();
  end
endmodule